// File: doc/BRIEF.md
# Serial Transmitter with Break Generation

This block turns bytes into an asynchronous serial bit stream. Software writes a byte into a one-entry holding register. The transmitter moves that byte into a shift register and sends it with the least significant bit first. Each frame is one low start bit, then 8 data bits, then an optional ninth bit, then one high stop bit. The format input `fmt9` chooses 10-bit or 11-bit frames. The ninth bit is taken from `bit9`. The line advances by exactly one bit on every `tick` pulse. Generating that pulse is the job of a separate rate divider.

A break request inserts blocks of zeros that are one frame long. A short pulse on `sbk` yields exactly one block. Holding `sbk` high yields back-to-back blocks, and a block that has started is never cut short. Every break is followed by at least one high bit. The enable `te` is sampled only at frame boundaries. Turning it on first sends one idle character of all ones. Turning it off lets the frame in flight complete before the line rests high.

The controller has six states:
- `S_OFF`: disabled, line high.
- `S_IDLE`: sending the idle character.
- `S_WAIT`: enabled, waiting for data.
- `S_FRAME`: sending a data frame.
- `S_BREAK`: sending a zero block.
- `S_MARK`: the single high bit after a break.

Every transition happens on a tick at a boundary. A boundary is any tick while in `S_OFF` or `S_WAIT`, or the tick that ends the last bit of the current unit. The transitions are:
- From `S_OFF`: to `S_IDLE` if `te` is high, otherwise stay in `S_OFF`.
- From `S_BREAK`: to `S_BREAK` again if both `sbk` and `te` are high, otherwise to `S_MARK`.
- From `S_WAIT`, `S_IDLE`, `S_FRAME` or `S_MARK`, checked in this order:
  - to `S_OFF` if `te` is low;
  - to `S_BREAK` if a break request is pending;
  - to `S_FRAME` if the holding register is full;
  - otherwise to `S_WAIT`.

Top module: `sertx_top`

## Requirements
- R1: During and right after reset, `txd` is 1 and `tdre` is 1.
- R2: With `fmt9`=0, a frame is 10 bits: a 0 start bit, data bits 0 to 7 in that order, and a 1 stop bit. `txd` changes only in the cycle after a `tick`.
- R3: With `fmt9`=1, a frame is 11 bits: the ninth bit, equal to `bit9`, is sent after data bit 7 and before the stop bit.
- R4: A data write makes `tdre` 0 in the next cycle. `tdre` returns to 1 on the tick that sends that byte's start bit. `tdre` changes on no other cycle.
- R5: A byte written while a frame is in flight has its start bit sent on the tick right after the previous stop bit.
- R6: When `te` goes from low to high, 10 (`fmt9`=0) or 11 (`fmt9`=1) high bits are sent before any data frame starts.
- R7: With `te` low and no frame in flight, `txd` stays 1 and a written byte is not sent.
- R8: Clearing `te` during a frame lets that frame complete, after which `txd` stays 1.
- R9: Raising and dropping `sbk` between ticks sends exactly one block of zeros: 10 zeros when `fmt9`=0, 11 zeros when `fmt9`=1.
- R10: While `sbk` stays high, zero blocks follow one another back to back. A block that has started always completes.
- R11: After the final break block, `txd` is 1 for at least one bit time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse marking each bit time |
| te | input | 1 | Transmitter enable |
| sbk | input | 1 | Break request |
| fmt9 | input | 1 | 1 selects 11-bit frames |
| bit9 | input | 1 | Ninth data bit for 11-bit frames |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| txd | output | 1 | Serial line |
| tdre | output | 1 | High when the holding register is empty |

## Verification
The framing path is tested with a table of six bytes that mixes 10-bit and 11-bit frames. The bytes include alternating bits, all zeros, all ones, and an edge-only pattern (0x81). This catches bit order errors, a wrong ninth-bit source, and stop-bit slips. Because consecutive table entries are written while the previous stop bit is still on the line, the table also shows whether frames abut with no gap.

Break tests cover three cases: a short pulse, a long hold released part-way through the second block, and the mark bit that follows. Together they tell one block apart from several, and an aborted block apart from a completed one. The enable tests cover writing while disabled, re-enabling, and disabling in mid-frame. They separate the idle preamble, the ignored write and the graceful finish.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        S_OFF,
        S_WAIT,
        S_IDLE,
        S_FRAME,
        S_BREAK,
        S_MARK
    } tx_state_t;

endpackage

// File: rtl/sertx_holdreg.sv
module sertx_holdreg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          take,
    output logic [DW-1:0] data,
    output logic          empty
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            empty <= 1'b1;
        end else if (wr_en) begin
            data  <= wr_data;
            empty <= 1'b0;
        end else if (take) begin
            empty <= 1'b1;
        end
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int SW = 11,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          ld,
    input  logic [SW-1:0] ld_word,
    input  logic [CW-1:0] ld_cnt,
    output logic          txd,
    output logic          last
);

    logic [SW-1:0] sh_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q  <= '1;
            cnt_q <= '0;
        end else if (ld) begin
            sh_q  <= ld_word;
            cnt_q <= ld_cnt;
        end else if (tick && (cnt_q != '0)) begin
            sh_q  <= {1'b1, sh_q[SW-1:1]};
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        txd  = sh_q[0];
        last = (cnt_q == '0);
    end

endmodule

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
    import sertx_pkg::*;
#(
    parameter int DW = 8,
    parameter int SW = DW + 3,
    parameter int CW = $clog2(SW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          te,
    input  logic          sbk,
    input  logic          fmt9,
    input  logic          bit9,
    input  logic          empty,
    input  logic          last,
    input  logic [DW-1:0] data,
    output logic          ld,
    output logic [SW-1:0] ld_word,
    output logic [CW-1:0] ld_cnt,
    output logic          take,
    output tx_state_t     state
);

    localparam logic [CW-1:0] SPAN_SHORT = CW'(DW + 1);
    localparam logic [CW-1:0] SPAN_LONG  = CW'(DW + 2);

    tx_state_t     state_q;
    tx_state_t     nxt;
    logic          pend_q;
    logic          decide;
    logic [CW-1:0] span;

    assign decide = tick && ((state_q == S_OFF) || (state_q == S_WAIT) || last);
    assign span   = fmt9 ? SPAN_LONG : SPAN_SHORT;
    assign state  = state_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
        end else begin
            state_q <= nxt;
        end
    end

    // break request memory: raised by sbk outside a block, dropped when served
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (decide && (nxt == S_BREAK)) begin
            pend_q <= 1'b0;
        end else if (state_q == S_OFF) begin
            pend_q <= 1'b0;
        end else if (sbk && (state_q != S_BREAK)) begin
            pend_q <= 1'b1;
        end
    end

    // next state
    always_comb begin
        nxt = state_q;
        if (decide) begin
            unique case (state_q)
                S_OFF: begin
                    nxt = te ? S_IDLE : S_OFF;
                end
                S_BREAK: begin
                    nxt = (sbk && te) ? S_BREAK : S_MARK;
                end
                S_WAIT, S_IDLE, S_FRAME, S_MARK: begin
                    if (!te) begin
                        nxt = S_OFF;
                    end else if (pend_q) begin
                        nxt = S_BREAK;
                    end else if (!empty) begin
                        nxt = S_FRAME;
                    end else begin
                        nxt = S_WAIT;
                    end
                end
                default: nxt = S_OFF;
            endcase
        end
    end

    // outputs: what to load into the shifter on a boundary
    always_comb begin
        ld      = decide;
        take    = decide && (nxt == S_FRAME);
        ld_word = '1;
        ld_cnt  = '0;
        unique case (nxt)
            S_FRAME: begin
                ld_word = fmt9 ? {1'b1, bit9, data, 1'b0} : {2'b11, data, 1'b0};
                ld_cnt  = span;
            end
            S_BREAK: begin
                ld_word = '0;
                ld_cnt  = span;
            end
            S_IDLE: begin
                ld_word = '1;
                ld_cnt  = span;
            end
            default: begin
                ld_word = '1;
                ld_cnt  = '0;
            end
        endcase
    end

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              te,
    input  logic              sbk,
    input  logic              fmt9,
    input  logic              bit9,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tdre
);

    localparam int SH_W  = DATA_W + 3;
    localparam int CNT_W = $clog2(SH_W + 1);

    logic [DATA_W-1:0] hold_w;
    logic              empty_w;
    logic              take_w;
    logic              ld_w;
    logic [SH_W-1:0]   word_w;
    logic [CNT_W-1:0]  cnt_w;
    logic              last_w;
    tx_state_t         state_w;

    sertx_holdreg #(.DW(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .take    (take_w),
        .data    (hold_w),
        .empty   (empty_w)
    );

    sertx_ctrl #(.DW(DATA_W), .SW(SH_W), .CW(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .te      (te),
        .sbk     (sbk),
        .fmt9    (fmt9),
        .bit9    (bit9),
        .empty   (empty_w),
        .last    (last_w),
        .data    (hold_w),
        .ld      (ld_w),
        .ld_word (word_w),
        .ld_cnt  (cnt_w),
        .take    (take_w),
        .state   (state_w)
    );

    sertx_shifter #(.SW(SH_W), .CW(CNT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ld      (ld_w),
        .ld_word (word_w),
        .ld_cnt  (cnt_w),
        .txd     (txd),
        .last    (last_w)
    );

    assign tdre = empty_w;

endmodule

// File: rtl/sertx_checker.sv
module sertx_checker
    import sertx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      tick,
    input logic      te,
    input logic      sbk,
    input logic      wr_en,
    input logic      txd,
    input logic      tdre,
    input logic      last,
    input tx_state_t state
);

    // R1: reset leaves the line high and the register empty
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (txd && tdre));

    // R2: the line moves only on bit-rate ticks
    a_r2_tick_paced: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(txd));

    // R4: a write empties nothing, it fills the register
    a_r4_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tdre);

    // R4: without tick or write the flag holds
    a_r4_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en) |=> $stable(tdre));

    // R6: leaving the disabled state begins with a high bit
    a_r6_idle_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_OFF) && tick && te) |=> txd);

    // R7: disabled line rests high
    a_r7_off_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_OFF) |-> txd);

    // R10: a break block is all zeros
    a_r10_break_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_BREAK) |-> !txd);

    // R11: the last break block is followed by a high bit
    a_r11_mark_after: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_BREAK) && last && tick && !(sbk && te)) |=> txd);

endmodule

bind sertx_top sertx_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .te    (te),
    .sbk   (sbk),
    .wr_en (wr_en),
    .txd   (txd),
    .tdre  (tdre),
    .last  (last_w),
    .state (state_w)
);

// File: tb/sertx_top_bench.sv
module sertx_top_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       te = 1'b0;
    logic       sbk = 1'b0;
    logic       fmt9 = 1'b0;
    logic       bit9 = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       txd;
    logic       tdre;

    int n_chk = 0;
    int n_fail = 0;

    // {fmt9, bit9, byte}
    localparam logic [9:0] VEC [0:5] = '{10'h055, 10'h0A3, 10'h300, 10'h2FF, 10'h081, 10'h33C};

    always #4 clk = ~clk;

    sertx_top u_sertx_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .te      (te),
        .sbk     (sbk),
        .fmt9    (fmt9),
        .bit9    (bit9),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .txd     (txd),
        .tdre    (tdre)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step_tick(output logic b);
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
        b = txd;
    endtask

    task automatic grab(input int n, output logic [31:0] bits);
        logic b;
        bits = '0;
        for (int k = 0; k < n; k++) begin
            step_tick(b);
            bits[k] = b;
        end
    endtask

    task automatic put(input logic [7:0] d);
        @(negedge clk) begin wr_en = 1'b1; wr_data = d; end
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] bits;
        logic [31:0] rest;
        logic [31:0] exp;
        logic        b0;
        logic        b;
        int          len;

        repeat (3) @(negedge clk);
        chk("R1 txd in reset", 32'(txd), 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd after reset", 32'(txd), 32'd1);
        chk("R1 tdre after reset", 32'(tdre), 32'd1);

        // R7: disabled, written byte stays put
        put(8'h5A);
        chk("R4 write clears tdre", 32'(tdre), 32'd0);
        grab(12, bits);
        chk("R7 disabled line high", bits, 32'hFFF);

        // R6: enabling queues an idle character, then the byte
        te = 1'b1;
        grab(11, bits);
        chk("R6 idle char then start", bits, 32'h3FF);
        grab(9, bits);
        chk("R2 frame of 0x5A", bits, 32'h15A);
        step_tick(b);
        chk("R2 idle after stop", 32'(b), 32'd1);

        // table of frames, written back to back (R2 R3 R5)
        for (int i = 0; i < 6; i++) begin
            fmt9 = VEC[i][9];
            bit9 = VEC[i][8];
            len  = VEC[i][9] ? 11 : 10;
            exp  = VEC[i][9] ? 32'({1'b1, VEC[i][8], VEC[i][7:0], 1'b0})
                             : 32'({1'b1, VEC[i][7:0], 1'b0});
            put(VEC[i][7:0]);
            chk("R4 tdre low after write", 32'(tdre), 32'd0);
            step_tick(b0);
            chk("R4 tdre high at start bit", 32'(tdre), 32'd1);
            grab(len - 1, rest);
            bits = (rest << 1) | 32'(b0);
            chk(VEC[i][9] ? "R3 R5 long frame" : "R2 R5 short frame", bits, exp);
        end
        step_tick(b);
        chk("R2 idle after table", 32'(b), 32'd1);

        // R9 R11: single break pulse, short frames
        fmt9 = 1'b0;
        @(negedge clk) sbk = 1'b1;
        @(negedge clk) sbk = 1'b0;
        grab(12, bits);
        chk("R9 one block of ten zeros", bits & 32'h3FF, 32'h0);
        chk("R11 mark after break", bits >> 10, 32'h3);

        // R10: held break, long frames, released inside the second block
        fmt9 = 1'b1;
        @(negedge clk) sbk = 1'b1;
        @(negedge clk);
        grab(15, bits);
        chk("R10 held break zeros", bits, 32'h0);
        sbk = 1'b0;
        grab(8, bits);
        chk("R10 second block completes then mark", bits, 32'h80);
        step_tick(b);

        // R8: disable mid-frame
        fmt9 = 1'b0;
        put(8'hC6);
        step_tick(b0);
        chk("R8 start bit", 32'(b0), 32'd0);
        te = 1'b0;
        grab(9, bits);
        chk("R8 frame completes after disable", bits, 32'h1C6);
        grab(4, bits);
        chk("R8 line rests high", bits, 32'hF);

        // R7: write while disabled is not sent
        put(8'h11);
        grab(4, bits);
        chk("R7 no send while disabled", bits, 32'hF);

        // R6: re-enable, idle char then queued byte
        te = 1'b1;
        grab(20, bits);
        exp = 32'({1'b1, 8'h11, 1'b0, 10'h3FF});
        chk("R6 preamble then queued byte", bits, exp);

        finish_run();
    end

endmodule